// File: doc/BRIEF.md
# Dual Warp Instruction Issue Scheduler

This block is the issue stage of a multiprocessor that keeps a pool of resident warps. Each warp is a group of 32 lanes that run the same instruction. Two schedulers work side by side. Scheduler 0 owns the even-numbered warps and scheduler 1 owns the odd-numbered warps. In each cycle, each scheduler may send the next instruction of one of its ready warps to an execution unit. There are three unit types. Each scheduler has a private 16-lane core group. The two schedulers share one 16-lane load/store group and one 4-lane special-function group.

A 32-lane warp occupies a unit for several cycles: two cycles on a 16-lane unit and eight cycles on the 4-lane unit. The block tracks how long each unit stays occupied and resolves collisions between the two schedulers on the shared units. It also splits a divergent branch into two issues, each carrying a predicate mask. The upstream logic presents, for each warp, a ready flag, the unit code of the next instruction, the active-lane mask, a divergence flag and a taken-lane mask. An issue decision is visible on the outputs during the cycle in which it is made. It takes effect at the next rising clock edge, which is when the upstream logic may advance that warp.

Top module: `dual_warp_issue`

## Requirements
- R1: Scheduler 0 issues only even warp IDs and scheduler 1 issues only odd warp IDs. Each scheduler issues at most one warp per cycle, and both schedulers may issue in the same cycle.
- R2: A warp can be issued only when all of the following hold:
  - its ready bit is high;
  - its active mask is nonzero;
  - its unit code is one of 0 (core group), 1 (load/store group) or 2 (special-function group);
  - the target unit is free in that cycle.
  Unit code 3 is never issued.
- R3: Each scheduler keeps a round-robin pointer over its own warps, starting at its lowest warp ID after reset. After a warp issues, the next search starts at the following warp ID of the same parity and wraps around.
- R4: A core-group issue goes to the issuing scheduler's own core group. A 16-lane unit that accepts an issue in cycle t can accept the next issue no earlier than cycle t+2. unitBusy bit 0 is the scheduler 0 core group, bit 1 the scheduler 1 core group, bit 2 the load/store group and bit 3 the special-function group. The bit is high in the cycles in which that unit cannot accept an issue.
- R5: The special-function group, after accepting an issue in cycle t, can accept the next issue no earlier than cycle t+8. Its busy bit is high in cycles t+1 to t+7.
- R6: When both schedulers select the same free shared unit in the same cycle:
  - scheduler 0 wins the first such conflict after reset;
  - the winner then alternates on every further conflict;
  - the losing scheduler issues nothing in that cycle.
- R7: A warp stalled on a busy unit does not prevent its scheduler from issuing, in the same cycle, another ready warp whose unit is free.
- R8: A divergent instruction with two non-empty paths issues twice:
  - first with mask (active AND taken) and issLast 0;
  - then, on that warp's next issue, with mask (active AND NOT taken) and issLast 1.
- R9: If one path of a divergent instruction is empty, that path is skipped. The instruction issues once, with the non-empty path's mask and issLast 1, and no second issue is left pending.
- R10: A non-divergent instruction issues once, with its full active mask and issLast 1.
- R11: During and straight after reset, no unit is busy and no scheduler issues until a warp becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| warpReady | input | NUM_WARPS | Next instruction of the warp is ready |
| warpUnit | input | 2*NUM_WARPS | Unit code per warp: 0 core, 1 load/store, 2 special-function, 3 none |
| warpMask | input | NUM_WARPS*WARP_LANES | Active-lane mask per warp |
| warpDiverge | input | NUM_WARPS | Next instruction is a divergent branch |
| warpTaken | input | NUM_WARPS*WARP_LANES | Lanes that take the branch, per warp |
| issValid | output | 2 | Scheduler s issues this cycle |
| issWarp | output | 2*$clog2(NUM_WARPS) | Issued warp ID per scheduler |
| issUnit | output | 4 | Target unit code per scheduler |
| issMask | output | 2*WARP_LANES | Predicate mask carried by the issue |
| issLast | output | 2 | Issue completes the warp's instruction |
| unitBusy | output | 4 | Occupancy of core0, core1, load/store, special-function |

## Verification
Two functions can fall in the same cycle: both schedulers issuing at once, and both schedulers competing for one shared unit. The concurrent case is provoked by making an even warp ready for the core group and an odd warp ready for the special-function group in the same cycle; the bench expects both valid bits high. The conflict is provoked by holding one even and one odd warp ready for the load/store group over several free windows of that unit. The bench judges it by which scheduler's valid bit rises in each window (0, then 1, then 0) and expects the other scheduler to be silent in that window.

// File: rtl/warp_issue_pkg.sv
`timescale 1ns/1ps
package warp_issue_pkg;
  typedef enum logic [1:0] {
    UNIT_CORE = 2'd0,
    UNIT_LDST = 2'd1,
    UNIT_SFU  = 2'd2,
    UNIT_NONE = 2'd3
  } unitKindT;

  // control-to-datapath strobe, one per scheduler
  typedef struct packed {
    logic     fire;
    unitKindT unit;
  } issueStrobeT;
endpackage

// File: rtl/warp_issue_ctrl.sv
`timescale 1ns/1ps
module warp_issue_ctrl
  import warp_issue_pkg::*;
#(
  parameter int NUM_WARPS  = 8,
  parameter int WARP_LANES = 32,
  parameter int CORE_LANES = 16,
  parameter int LDST_LANES = 16,
  parameter int SFU_LANES  = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_WARPS-1:0]           warpLive,
  input  logic [2*NUM_WARPS-1:0]         warpUnit,
  output issueStrobeT                    strobe [2],
  output logic [$clog2(NUM_WARPS)-1:0]   pickWarp [2],
  output logic [3:0]                     unitBusy
);
  localparam int HALF      = NUM_WARPS / 2;
  localparam int WID_W     = $clog2(NUM_WARPS);
  localparam int LOC_W     = WID_W - 1;
  localparam int CORE_HOLD = WARP_LANES / CORE_LANES;
  localparam int LDST_HOLD = WARP_LANES / LDST_LANES;
  localparam int SFU_HOLD  = WARP_LANES / SFU_LANES;
  localparam int MAX_HOLD  = (SFU_HOLD > CORE_HOLD) ?
                             ((SFU_HOLD > LDST_HOLD) ? SFU_HOLD : LDST_HOLD) :
                             ((CORE_HOLD > LDST_HOLD) ? CORE_HOLD : LDST_HOLD);
  localparam int CNT_W     = $clog2(MAX_HOLD + 1);

  // slot 0/1: private core groups, slot 2: load/store, slot 3: special-function
  function automatic int slotOf(input int sch, input unitKindT u);
    case (u)
      UNIT_CORE: return sch;
      UNIT_LDST: return 2;
      default:   return 3;
    endcase
  endfunction

  function automatic int holdOf(input int slot);
    if (slot < 2)  return CORE_HOLD;
    if (slot == 2) return LDST_HOLD;
    return SFU_HOLD;
  endfunction

  logic [3:0]       slotFree;
  logic [3:0]       slotLoad;
  logic [HALF-1:0]  cand [2];
  logic [1:0]       pickValid;
  logic [LOC_W-1:0] pickLoc [2];
  unitKindT         pickUnit [2];
  logic [LOC_W-1:0] rrPtr [2];
  logic             prioSel;
  logic             conflict;
  logic [1:0]       grant;

  // eligibility and round-robin selection per scheduler
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < HALF; i++) begin
        int w;
        unitKindT u;
        w = 2 * i + s;
        u = unitKindT'(warpUnit[2*w +: 2]);
        cand[s][i] = warpLive[w] && (u != UNIT_NONE) && slotFree[slotOf(s, u)];
      end
      pickValid[s] = 1'b0;
      pickLoc[s]   = '0;
      pickUnit[s]  = UNIT_NONE;
      for (int off = 0; off < HALF; off++) begin
        int idx;
        idx = int'(rrPtr[s]) + off;
        if (idx >= HALF) idx = idx - HALF;
        if (!pickValid[s] && cand[s][idx]) begin
          pickValid[s] = 1'b1;
          pickLoc[s]   = LOC_W'(idx);
          pickUnit[s]  = unitKindT'(warpUnit[2*(2*idx+s) +: 2]);
        end
      end
    end
  end

  // cross-scheduler arbitration on shared units
  always_comb begin
    conflict = pickValid[0] && pickValid[1] && (pickUnit[0] == pickUnit[1]) &&
               (pickUnit[0] != UNIT_CORE);
    grant[0] = pickValid[0] && !(conflict && prioSel);
    grant[1] = pickValid[1] && !(conflict && !prioSel);
    for (int k = 0; k < 4; k++) begin
      slotLoad[k] = (grant[0] && slotOf(0, pickUnit[0]) == k) ||
                    (grant[1] && slotOf(1, pickUnit[1]) == k);
    end
    for (int s = 0; s < 2; s++) begin
      strobe[s].fire = grant[s];
      strobe[s].unit = pickUnit[s];
      pickWarp[s]    = {pickLoc[s], 1'(s)};
    end
  end

  // occupancy counter per unit slot
  for (genvar k = 0; k < 4; k++) begin : gSlot
    localparam int HOLD = holdOf(k);
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (slotLoad[k]) cnt <= CNT_W'(HOLD - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign slotFree[k] = (cnt == '0);
    assign unitBusy[k] = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr[0] <= '0;
      rrPtr[1] <= '0;
      prioSel  <= 1'b0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (grant[s]) rrPtr[s] <= (pickLoc[s] == LOC_W'(HALF - 1)) ? '0 : pickLoc[s] + 1'b1;
      end
      if (conflict) prioSel <= ~prioSel;
    end
  end

  // ---------------- assertions ----------------
  logic             seenConflict;
  logic             lastWin;
  logic [CNT_W-1:0] sfuAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenConflict <= 1'b0;
      lastWin      <= 1'b0;
      sfuAge       <= CNT_W'(SFU_HOLD);
    end else begin
      if (conflict) begin
        seenConflict <= 1'b1;
        lastWin      <= grant[1];
      end
      if (slotLoad[3])                       sfuAge <= CNT_W'(1);
      else if (sfuAge < CNT_W'(SFU_HOLD))    sfuAge <= sfuAge + 1'b1;
    end
  end

  assert_unit_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant != 2'b00) |-> ((!grant[0] || pickUnit[0] != UNIT_NONE) &&
                          (!grant[1] || pickUnit[1] != UNIT_NONE)));

  assert_first_winner_R6: assert property (@(posedge clk) disable iff (!rstN)
    (conflict && !seenConflict) |-> (grant[0] && !grant[1]));

  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (conflict && seenConflict) |-> (grant[1] != lastWin) && (grant[0] == lastWin));

  assert_sfu_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    slotLoad[3] |-> (sfuAge >= CNT_W'(SFU_HOLD)));

  if (CORE_HOLD > 1) begin : gCoreHold
    for (genvar s = 0; s < 2; s++) begin : gSch
      assert_core_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
        (grant[s] && pickUnit[s] == UNIT_CORE) |=> (unitBusy[s] && !(grant[s] && pickUnit[s] == UNIT_CORE)));
    end
  end
endmodule

// File: rtl/warp_issue_dpath.sv
`timescale 1ns/1ps
module warp_issue_dpath
  import warp_issue_pkg::*;
#(
  parameter int NUM_WARPS  = 8,
  parameter int WARP_LANES = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_WARPS-1:0]            warpReady,
  input  logic [NUM_WARPS*WARP_LANES-1:0] warpMask,
  input  logic [NUM_WARPS-1:0]            warpDiverge,
  input  logic [NUM_WARPS*WARP_LANES-1:0] warpTaken,
  input  issueStrobeT                     strobe [2],
  input  logic [$clog2(NUM_WARPS)-1:0]    pickWarp [2],
  output logic [NUM_WARPS-1:0]            warpLive,
  output logic [2*WARP_LANES-1:0]         issMask,
  output logic [1:0]                      issLast
);
  localparam int L = WARP_LANES;

  logic [NUM_WARPS-1:0] pending;   // second branch path still owed

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      warpLive[w] = warpReady[w] && (warpMask[w*L +: L] != '0);
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      int w;
      logic [L-1:0] act, takenPart, otherPart, pathMask;
      logic pathLast;
      w         = int'(pickWarp[s]);
      act       = warpMask[w*L +: L];
      takenPart = act & warpTaken[w*L +: L];
      otherPart = act & ~warpTaken[w*L +: L];
      if (warpDiverge[w] && !pending[w]) begin
        if (takenPart != '0) begin
          pathMask = takenPart;
          pathLast = (otherPart == '0);
        end else begin
          pathMask = otherPart;
          pathLast = 1'b1;
        end
      end else if (warpDiverge[w]) begin
        pathMask = otherPart;
        pathLast = 1'b1;
      end else begin
        pathMask = act;
        pathLast = 1'b1;
      end
      issMask[s*L +: L] = strobe[s].fire ? pathMask : '0;
      issLast[s]        = strobe[s].fire && pathLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else begin
      for (int s = 0; s < 2; s++) begin
        if (strobe[s].fire) pending[pickWarp[s]] <= !issLast[s];
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gChk
    assert_mask_within_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe[s].fire |-> ((issMask[s*L +: L] & ~warpMask[int'(pickWarp[s])*L +: L]) == '0));
    assert_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobe[s].fire |-> (issMask[s*L +: L] != '0));
    assert_pending_last_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[s].fire && pending[pickWarp[s]]) |-> issLast[s]);
  end
endmodule

// File: rtl/dual_warp_issue.sv
`timescale 1ns/1ps
module dual_warp_issue
  import warp_issue_pkg::*;
#(
  parameter int NUM_WARPS  = 8,
  parameter int WARP_LANES = 32,
  parameter int CORE_LANES = 16,
  parameter int LDST_LANES = 16,
  parameter int SFU_LANES  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_WARPS-1:0]            warpReady,
  input  logic [2*NUM_WARPS-1:0]          warpUnit,
  input  logic [NUM_WARPS*WARP_LANES-1:0] warpMask,
  input  logic [NUM_WARPS-1:0]            warpDiverge,
  input  logic [NUM_WARPS*WARP_LANES-1:0] warpTaken,
  output logic [1:0]                      issValid,
  output logic [2*$clog2(NUM_WARPS)-1:0]  issWarp,
  output logic [3:0]                      issUnit,
  output logic [2*WARP_LANES-1:0]         issMask,
  output logic [1:0]                      issLast,
  output logic [3:0]                      unitBusy
);
  localparam int WID_W = $clog2(NUM_WARPS);

  issueStrobeT           strobe [2];
  logic [WID_W-1:0]      pickWarp [2];
  logic [NUM_WARPS-1:0]  warpLive;

  warp_issue_ctrl #(
    .NUM_WARPS(NUM_WARPS), .WARP_LANES(WARP_LANES), .CORE_LANES(CORE_LANES),
    .LDST_LANES(LDST_LANES), .SFU_LANES(SFU_LANES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .warpLive(warpLive), .warpUnit(warpUnit),
    .strobe(strobe), .pickWarp(pickWarp), .unitBusy(unitBusy)
  );

  warp_issue_dpath #(.NUM_WARPS(NUM_WARPS), .WARP_LANES(WARP_LANES)) dpath_i (
    .clk(clk), .rstN(rstN), .warpReady(warpReady), .warpMask(warpMask),
    .warpDiverge(warpDiverge), .warpTaken(warpTaken), .strobe(strobe),
    .pickWarp(pickWarp), .warpLive(warpLive), .issMask(issMask), .issLast(issLast)
  );

  for (genvar s = 0; s < 2; s++) begin : gOut
    assign issValid[s]                 = strobe[s].fire;
    assign issWarp[s*WID_W +: WID_W]   = pickWarp[s];
    assign issUnit[s*2 +: 2]           = strobe[s].unit;

    assert_parity_R1: assert property (@(posedge clk) disable iff (!rstN)
      issValid[s] |-> (issWarp[s*WID_W] == 1'(s)));
  end
endmodule

// File: tb/dual_warp_issue_tb_top.sv
`timescale 1ns/1ps
module dual_warp_issue_tb_top;
  localparam int NW = 8;
  localparam int L  = 32;
  localparam int WW = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NW-1:0]   warpReady = '0;
  logic [2*NW-1:0] warpUnit = '0;
  logic [NW*L-1:0] warpMask = '0;
  logic [NW-1:0]   warpDiverge = '0;
  logic [NW*L-1:0] warpTaken = '0;
  logic [1:0]      issValid;
  logic [2*WW-1:0] issWarp;
  logic [3:0]      issUnit;
  logic [2*L-1:0]  issMask;
  logic [1:0]      issLast;
  logic [3:0]      unitBusy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  dual_warp_issue dut_i (
    .clk(clk), .rstN(rstN), .warpReady(warpReady), .warpUnit(warpUnit),
    .warpMask(warpMask), .warpDiverge(warpDiverge), .warpTaken(warpTaken),
    .issValid(issValid), .issWarp(issWarp), .issUnit(issUnit), .issMask(issMask),
    .issLast(issLast), .unitBusy(unitBusy)
  );

  task automatic clearAll();
    warpReady = '0; warpUnit = '0; warpMask = '0; warpDiverge = '0; warpTaken = '0;
  endtask

  task automatic setWarp(input int w, input bit rdy, input int unit,
                         input logic [31:0] mask, input bit div, input logic [31:0] taken);
    warpReady[w]          = rdy;
    warpUnit[2*w +: 2]    = 2'(unit);
    warpMask[w*L +: L]    = mask;
    warpDiverge[w]        = div;
    warpTaken[w*L +: L]   = taken;
  endtask

  // move to 1 ns after the next rising edge
  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  // wait until the falling edge, where outputs are sampled
  task automatic settle();
    #3;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    clearAll();
    repeat (2) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  task automatic checkIssue(input int s, input bit expV, input int expW, input int expU,
                            input logic [31:0] expM, input bit expL, input string tag);
    bit v, l;
    int aw, au;
    logic [31:0] am;
    v  = issValid[s];
    aw = int'(issWarp[s*WW +: WW]);
    au = int'(issUnit[s*2 +: 2]);
    am = issMask[s*L +: L];
    l  = issLast[s];
    checks++;
    if (v !== expV || (expV && (aw != expW || au != expU || am !== expM || l !== expL))) begin
      errors++;
      $display("FAIL %s sched%0d: actual v=%0b w=%0d u=%0d m=%h l=%0b expected v=%0b w=%0d u=%0d m=%h l=%0b",
               tag, s, v, aw, au, am, l, expV, expW, expU, expM, expL);
    end
  endtask

  task automatic checkBusy(input logic [3:0] exp, input string tag);
    checks++;
    if (unitBusy !== exp) begin
      errors++;
      $display("FAIL %s busy: actual %b expected %b", tag, unitBusy, exp);
    end
  endtask

  // R11: quiet after reset
  task automatic testReset();
    rstN = 1'b0;
    clearAll();
    @(negedge clk);
    checkBusy(4'b0000, "R11 in reset");
    checkIssue(0, 0, 0, 0, 0, 0, "R11 in reset");
    doReset();
    settle();
    checkBusy(4'b0000, "R11 after release");
    checkIssue(1, 0, 0, 0, 0, 0, "R11 after release");
  endtask

  // R4, R10: 16-lane core group occupancy and plain mask
  task automatic testCoreHold();
    doReset();
    setWarp(2, 1, 0, 32'h0000FFFF, 0, 0);
    settle();
    checkIssue(0, 1, 2, 0, 32'h0000FFFF, 1, "R10 R4 first issue");
    checkBusy(4'b0000, "R4 issue cycle");
    nextCycle(); settle();
    checkIssue(0, 0, 0, 0, 0, 0, "R4 busy cycle");
    checkBusy(4'b0001, "R4 busy cycle");
    nextCycle(); settle();
    checkIssue(0, 1, 2, 0, 32'h0000FFFF, 1, "R4 reissue at t+2");
    checkBusy(4'b0000, "R4 free at t+2");
    nextCycle();
  endtask

  // R5: special-function group window
  task automatic testSfuHold();
    doReset();
    setWarp(1, 1, 2, 32'h0000000F, 0, 0);
    settle();
    checkIssue(1, 1, 1, 2, 32'h0000000F, 1, "R5 first issue");
    for (int c = 1; c < 8; c++) begin
      nextCycle(); settle();
      checkIssue(1, 0, 0, 0, 0, 0, "R5 blocked");
      checkBusy(4'b1000, "R5 busy");
    end
    nextCycle(); settle();
    checkIssue(1, 1, 1, 2, 32'h0000000F, 1, "R5 reissue at t+8");
    nextCycle();
  endtask

  // R3: round-robin order with wrap
  task automatic testRoundRobin();
    int expSeq [4] = '{0, 2, 4, 0};
    doReset();
    setWarp(0, 1, 0, 32'hFFFFFFFF, 0, 0);
    setWarp(2, 1, 0, 32'hFFFFFFFF, 0, 0);
    setWarp(4, 1, 0, 32'hFFFFFFFF, 0, 0);
    for (int k = 0; k < 4; k++) begin
      settle();
      checkIssue(0, 1, expSeq[k], 0, 32'hFFFFFFFF, 1, "R3 round-robin");
      nextCycle(); settle();
      checkIssue(0, 0, 0, 0, 0, 0, "R3 gap");
      nextCycle();
    end
  endtask

  // R6: shared load/store conflict alternates
  task automatic testConflict();
    doReset();
    setWarp(0, 1, 1, 32'h000000FF, 0, 0);
    setWarp(1, 1, 1, 32'h0000FF00, 0, 0);
    settle();
    checkIssue(0, 1, 0, 1, 32'h000000FF, 1, "R6 first conflict winner");
    checkIssue(1, 0, 0, 0, 0, 0, "R6 first conflict loser");
    nextCycle(); settle();
    checkBusy(4'b0100, "R6 ldst busy");
    nextCycle(); settle();
    checkIssue(1, 1, 1, 1, 32'h0000FF00, 1, "R6 second conflict winner");
    checkIssue(0, 0, 0, 0, 0, 0, "R6 second conflict loser");
    nextCycle(); nextCycle(); settle();
    checkIssue(0, 1, 0, 1, 32'h000000FF, 1, "R6 third conflict winner");
    checkIssue(1, 0, 0, 0, 0, 0, "R6 third conflict loser");
    nextCycle();
  endtask

  // R1: both schedulers issue in one cycle
  task automatic testDualIssue();
    doReset();
    setWarp(0, 1, 0, 32'h12345678, 0, 0);
    setWarp(1, 1, 2, 32'h80000001, 0, 0);
    settle();
    checkIssue(0, 1, 0, 0, 32'h12345678, 1, "R1 even to core");
    checkIssue(1, 1, 1, 2, 32'h80000001, 1, "R1 odd to sfu");
    nextCycle(); settle();
    checkBusy(4'b1001, "R1 core0 and sfu busy");
    nextCycle();
  endtask

  // R7: stalled warp does not block another
  task automatic testBypass();
    doReset();
    setWarp(0, 1, 2, 32'h000000FF, 0, 0);
    setWarp(2, 1, 0, 32'h0000FF00, 0, 0);
    settle();
    checkIssue(0, 1, 0, 2, 32'h000000FF, 1, "R7 sfu issue");
    nextCycle(); settle();
    checkIssue(0, 1, 2, 0, 32'h0000FF00, 1, "R7 core while sfu busy");
    nextCycle(); settle();
    checkIssue(0, 0, 0, 0, 0, 0, "R7 both busy");
    nextCycle(); settle();
    checkIssue(0, 1, 2, 0, 32'h0000FF00, 1, "R7 skip stalled warp");
    nextCycle();
  endtask

  // R8: two-path divergence
  task automatic testDiverge();
    doReset();
    setWarp(3, 1, 0, 32'h00FF00FF, 1, 32'h0000FFFF);
    settle();
    checkIssue(1, 1, 3, 0, 32'h000000FF, 0, "R8 taken path");
    nextCycle(); nextCycle(); settle();
    checkIssue(1, 1, 3, 0, 32'h00FF0000, 1, "R8 complement path");
    nextCycle(); nextCycle(); settle();
    checkIssue(1, 1, 3, 0, 32'h000000FF, 0, "R8 next instruction restarts");
    nextCycle();
  endtask

  // R9: empty paths skipped
  task automatic testSkip();
    doReset();
    setWarp(5, 1, 1, 32'h000000FF, 1, 32'h0000FF00);
    settle();
    checkIssue(1, 1, 5, 1, 32'h000000FF, 1, "R9 empty taken path");
    doReset();
    setWarp(5, 1, 1, 32'h000000FF, 1, 32'h000000FF);
    settle();
    checkIssue(1, 1, 5, 1, 32'h000000FF, 1, "R9 empty complement");
    nextCycle(); nextCycle(); settle();
    checkIssue(1, 1, 5, 1, 32'h000000FF, 1, "R9 nothing pending");
    nextCycle();
  endtask

  // R2: eligibility
  task automatic testEligible();
    doReset();
    setWarp(0, 1, 3, 32'hFFFFFFFF, 0, 0);
    setWarp(2, 1, 0, 32'h00000000, 0, 0);
    setWarp(4, 0, 0, 32'hFFFFFFFF, 0, 0);
    settle();
    checkIssue(0, 0, 0, 0, 0, 0, "R2 none eligible");
    nextCycle();
    setWarp(6, 1, 0, 32'h00000001, 0, 0);
    settle();
    checkIssue(0, 1, 6, 0, 32'h00000001, 1, "R2 only eligible warp");
    nextCycle();
  endtask

  initial begin
    testReset();
    testCoreHold();
    testSfuHold();
    testRoundRobin();
    testConflict();
    testDualIssue();
    testBypass();
    testDiverge();
    testSkip();
    testEligible();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule